// File: doc/BRIEF.md
# Data Transaction Capture Registers

This block keeps a replayable record of the most recent data memory access. The load/store unit offers each access once, on a valid/ready handshake. The block then writes a descriptor into two slots, each with a transaction word, an address word and a data word. The descriptor holds the access kind, size, signedness, byte order, destination register, address space and byte-lane enables. An exception handler reads the slots back through a select-addressed read port and can reissue the access from them.

A single access writes slot one and clears the transaction word of slot two. A doubleword access also fills slot two for the second word. Slot two copies the slot-one descriptor, with the destination register advanced by one on loads. Slot one then carries a first-of-pair mark. A user-space access made outside supervisor mode is still recorded, and the block flags a privilege violation when it completes. A load that names an impossible destination register is refused. Such a load raises a sticky internal error flag and leaves every slot as it was.

A sequencer with five states controls the block:
- `ST_IDLE` accepts a request. It goes to `ST_FILL_LO`, or to `ST_REJECT` for an illegal register number.
- `ST_FILL_LO` writes slot one. It goes to `ST_FILL_HI` for a doubleword and to `ST_FINISH` otherwise.
- `ST_FILL_HI` writes slot two and goes to `ST_FINISH`.
- `ST_FINISH` signals completion and reports any violation, then returns to `ST_IDLE`.
- `ST_REJECT` signals completion of a refused request and returns to `ST_IDLE`.

Top module: `xcap_unit`

## Requirements
- R1: After reset, all six capture words read zero, `req_ready` is 1, and `acc_done`, `priv_viol` and `int_err` are 0.
- R2: An accepted access sets bit 0 (valid) of the slot-one transaction word. A store sets bit 1 (write) and leaves bits 10:6 at zero. A load writes its destination register number into bits 10:6. A non-doubleword access clears the whole slot-two transaction word.
- R3: Bit 11 (signed) is set only for a signed load, never for a store. Bit 12 (byte order) is set when the access is little-endian.
- R4: Bit 13 (supervisor space) is set exactly when the processor is in supervisor mode and the access is not a user-space access.
- R5: Bits 5:2 hold the lane enables, with `req_size` encoded as 0 byte, 1 halfword, 2 word, 3 doubleword. A byte at offset k (address bits 1:0) enables bit 3-k of the field. A halfword enables field bits 3:2 when address bit 1 is 0 and bits 1:0 when it is 1. A word or a doubleword enables all four.
- R6: The slot-one address word is the request address with bits 1:0 cleared. The slot-one data word holds the first store word for a store and zero for a load.
- R7: For a doubleword, slot two holds the slot-one transaction word without bit 14. On a load its register field is the destination plus one. The slot-one word additionally carries bit 14 (first of pair). The slot-two address is the slot-one address plus 4. On a store, the slot-two data word receives the second store word.
- R8: A non-doubleword access leaves the slot-two address and data words unchanged. A doubleword load leaves the slot-two data word unchanged.
- R9: A user-space access with supervisor mode off pulses `priv_viol` in the cycle `acc_done` is high. The access is still recorded.
- R10: A load with destination 0, or a doubleword load with destination 31, sets `int_err`. `int_err` then stays at 1 until reset. Such a load changes no capture word and completes without `priv_viol`.
- R11: `acc_done` rises 2 cycles after acceptance for a single access, 3 for a doubleword and 1 for a refused load. `req_ready` is low from acceptance until the cycle after `acc_done`, and a request offered while `req_ready` is low is ignored.
- R12: `rd_sel` values 0 to 5 read slot-one transaction, address and data, then slot-two transaction, address and data. Values 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Block idle, offer accepted this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_signed | input | 1 | Signed load |
| req_le | input | 1 | Little-endian byte order |
| req_dreg | input | 5 | Destination/source register number |
| req_super | input | 1 | Processor in supervisor mode |
| req_user | input | 1 | User-space access variant |
| req_addr | input | DW | Byte address of the access |
| req_wdata_a | input | DW | First store word |
| req_wdata_b | input | DW | Second store word (doubleword) |
| acc_done | output | 1 | Recording finished (one cycle) |
| priv_viol | output | 1 | Privilege violation, valid with acc_done |
| int_err | output | 1 | Sticky illegal-register error |
| rd_sel | input | 3 | Capture word select |
| rd_data | output | DW | Selected capture word |

## Verification
The bench builds the block with the default word width of 32 and a 5-bit register field. With these values the 4-lane enable decode and the 15-bit transaction layout are in force. The 5-bit field also makes register 31 the doubleword overflow case. The stimulus visits all four byte offsets, both halfword positions and every address-space combination. It includes doubleword records followed by single ones, which shows that slot two keeps its address and data. It also offers requests while the block is busy.

// File: rtl/xcap_pkg.sv
`timescale 1ns/100ps
package xcap_pkg;
    localparam int RN_W      = 5;
    localparam int BE_W      = 4;
    localparam int TX_VALID  = 0;
    localparam int TX_WRITE  = 1;
    localparam int TX_BE_LO  = 2;
    localparam int TX_REG_LO = TX_BE_LO + BE_W;
    localparam int TX_SIGNED = TX_REG_LO + RN_W;
    localparam int TX_BORD   = TX_SIGNED + 1;
    localparam int TX_SUPER  = TX_BORD + 1;
    localparam int TX_FIRST  = TX_SUPER + 1;
    localparam int SEL_W     = 3;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_LO,
        ST_FILL_HI,
        ST_FINISH,
        ST_REJECT
    } seq_state_e;

    typedef struct packed {
        logic            store;
        acc_size_e       size;
        logic            sgn;
        logic            le;
        logic [RN_W-1:0] dreg;
        logic            sup;
        logic            usr;
    } acc_ctl_t;
endpackage

// File: rtl/xcap_lane_dec.sv
`timescale 1ns/100ps
module xcap_lane_dec
    import xcap_pkg::*;
#(
    parameter int LANES = 4
) (
    input  acc_size_e                    size,
    input  logic [$clog2(LANES)-1:0]     offset,
    output logic [LANES-1:0]             lanes
);
    localparam int OFW = $clog2(LANES);
    localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

    logic [OFW-1:0] half_off;

    always_comb begin
        half_off = offset & ~OFW'(1);
        unique case (size)
            SZ_BYTE:  lanes = ONE_LANE << (OFW'(LANES - 1) - offset);
            SZ_HALF:  lanes = TWO_LANE << (OFW'(LANES - 2) - half_off);
            default:  lanes = '1;
        endcase
    end
endmodule

// File: rtl/xcap_desc_build.sv
`timescale 1ns/100ps
module xcap_desc_build
    import xcap_pkg::*;
#(
    parameter int DW = 32
) (
    input  acc_ctl_t          ctl,
    input  logic [BE_W-1:0]   lanes,
    input  logic [DW-1:0]     addr,
    input  logic [DW-1:0]     wdata_a,
    input  logic [DW-1:0]     wdata_b,
    output logic [DW-1:0]     txn_lo,
    output logic [DW-1:0]     txn_hi,
    output logic [DW-1:0]     adr_lo,
    output logic [DW-1:0]     adr_hi,
    output logic [DW-1:0]     dat_lo,
    output logic [DW-1:0]     dat_hi
);
    localparam logic [DW-1:0] WORD_BYTES = DW'(DW / 8);
    localparam int            ALIGN_W    = $clog2(DW / 8);

    logic [DW-1:0] base;
    logic          is_load;
    logic          is_pair;

    always_comb begin
        is_load = !ctl.store;
        is_pair = (ctl.size == SZ_DOUBLE);

        base                         = '0;
        base[TX_VALID]               = 1'b1;
        base[TX_WRITE]               = ctl.store;
        base[TX_BE_LO +: BE_W]       = lanes;
        base[TX_REG_LO +: RN_W]      = is_load ? ctl.dreg : '0;
        base[TX_SIGNED]              = is_load && ctl.sgn;
        base[TX_BORD]                = ctl.le;
        base[TX_SUPER]               = ctl.sup && !ctl.usr;

        txn_lo                       = base;
        txn_lo[TX_FIRST]             = is_pair;

        txn_hi                       = base;
        if (is_load)
            txn_hi[TX_REG_LO +: RN_W] = ctl.dreg + RN_W'(1);

        adr_lo                       = {addr[DW-1:ALIGN_W], {ALIGN_W{1'b0}}};
        adr_hi                       = adr_lo + WORD_BYTES;
        dat_lo                       = ctl.store ? wdata_a : '0;
        dat_hi                       = wdata_b;
    end
endmodule

// File: rtl/xcap_seq.sv
`timescale 1ns/100ps
module xcap_seq
    import xcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic bad_req,
    input  logic is_pair,
    input  logic priv_bad,
    output logic req_ready,
    output logic capture,
    output logic wr_lo,
    output logic wr_hi,
    output logic acc_done,
    output logic fin_ok,
    output logic priv_viol,
    output logic int_err
);
    seq_state_e state_q;
    seq_state_e state_d;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid && bad_req)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        capture   = 1'b0;
        wr_lo     = 1'b0;
        wr_hi     = 1'b0;
        acc_done  = 1'b0;
        fin_ok    = 1'b0;
        priv_viol = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    capture = 1'b1;
                    state_d = bad_req ? ST_REJECT : ST_FILL_LO;
                end
            end
            ST_FILL_LO: begin
                wr_lo   = 1'b1;
                state_d = is_pair ? ST_FILL_HI : ST_FINISH;
            end
            ST_FILL_HI: begin
                wr_hi   = 1'b1;
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                acc_done  = 1'b1;
                fin_ok    = 1'b1;
                priv_viol = priv_bad;
                state_d   = ST_IDLE;
            end
            ST_REJECT: begin
                acc_done = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign int_err = err_q;
endmodule

// File: rtl/xcap_regs.sv
`timescale 1ns/100ps
module xcap_regs
    import xcap_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_dhi,
    input  logic [DW-1:0]    txn_lo_in,
    input  logic [DW-1:0]    adr_lo_in,
    input  logic [DW-1:0]    dat_lo_in,
    input  logic [DW-1:0]    txn_hi_in,
    input  logic [DW-1:0]    adr_hi_in,
    input  logic [DW-1:0]    dat_hi_in,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    txn_lo,
    output logic [DW-1:0]    adr_lo,
    output logic [DW-1:0]    txn_hi,
    output logic [DW-1:0]    adr_hi
);
    logic [DW-1:0] dat_lo;
    logic [DW-1:0] dat_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_lo <= '0;
            adr_lo <= '0;
            dat_lo <= '0;
            txn_hi <= '0;
            adr_hi <= '0;
            dat_hi <= '0;
        end else begin
            if (wr_lo) begin
                txn_lo <= txn_lo_in;
                adr_lo <= adr_lo_in;
                dat_lo <= dat_lo_in;
                txn_hi <= '0;
            end
            if (wr_hi) begin
                txn_hi <= txn_hi_in;
                adr_hi <= adr_hi_in;
            end
            if (wr_dhi)
                dat_hi <= dat_hi_in;
        end
    end

    always_comb begin
        unique case (rd_sel)
            3'd0:    rd_data = txn_lo;
            3'd1:    rd_data = adr_lo;
            3'd2:    rd_data = dat_lo;
            3'd3:    rd_data = txn_hi;
            3'd4:    rd_data = adr_hi;
            3'd5:    rd_data = dat_hi;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/xcap_unit.sv
`timescale 1ns/100ps
module xcap_unit
    import xcap_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_store,
    input  logic [1:0]       req_size,
    input  logic             req_signed,
    input  logic             req_le,
    input  logic [RN_W-1:0]  req_dreg,
    input  logic             req_super,
    input  logic             req_user,
    input  logic [DW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata_a,
    input  logic [DW-1:0]    req_wdata_b,
    output logic             acc_done,
    output logic             priv_viol,
    output logic             int_err,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [DW-1:0]    rd_data
);
    localparam int LANES = DW / 8;
    localparam int OFW   = $clog2(LANES);

    acc_ctl_t      hold_ctl;
    logic [DW-1:0] hold_addr;
    logic [DW-1:0] hold_wa;
    logic [DW-1:0] hold_wb;

    logic          bad_req;
    logic          capture;
    logic          wr_lo;
    logic          wr_hi;
    logic          fin_ok;
    logic [LANES-1:0] lanes;

    logic [DW-1:0] nt_lo, nt_hi, na_lo, na_hi, nd_lo, nd_hi;
    logic [DW-1:0] t_lo_w, a_lo_w, t_hi_w, a_hi_w;

    // A load needs a legal destination; a pair load also needs the next one.
    always_comb begin
        bad_req = !req_store &&
                  ((req_dreg == '0) ||
                   (acc_size_e'(req_size) == SZ_DOUBLE && req_dreg == '1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_ctl  <= '0;
            hold_addr <= '0;
            hold_wa   <= '0;
            hold_wb   <= '0;
        end else if (capture) begin
            hold_ctl.store <= req_store;
            hold_ctl.size  <= acc_size_e'(req_size);
            hold_ctl.sgn   <= req_signed;
            hold_ctl.le    <= req_le;
            hold_ctl.dreg  <= req_dreg;
            hold_ctl.sup   <= req_super;
            hold_ctl.usr   <= req_user;
            hold_addr      <= req_addr;
            hold_wa        <= req_wdata_a;
            hold_wb        <= req_wdata_b;
        end
    end

    xcap_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bad_req   (bad_req),
        .is_pair   (hold_ctl.size == SZ_DOUBLE),
        .priv_bad  (hold_ctl.usr && !hold_ctl.sup),
        .req_ready (req_ready),
        .capture   (capture),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .acc_done  (acc_done),
        .fin_ok    (fin_ok),
        .priv_viol (priv_viol),
        .int_err   (int_err)
    );

    xcap_lane_dec #(.LANES(LANES)) u_lanes (
        .size   (hold_ctl.size),
        .offset (hold_addr[OFW-1:0]),
        .lanes  (lanes)
    );

    xcap_desc_build #(.DW(DW)) u_build (
        .ctl     (hold_ctl),
        .lanes   (lanes[BE_W-1:0]),
        .addr    (hold_addr),
        .wdata_a (hold_wa),
        .wdata_b (hold_wb),
        .txn_lo  (nt_lo),
        .txn_hi  (nt_hi),
        .adr_lo  (na_lo),
        .adr_hi  (na_hi),
        .dat_lo  (nd_lo),
        .dat_hi  (nd_hi)
    );

    xcap_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_dhi    (wr_hi && hold_ctl.store),
        .txn_lo_in (nt_lo),
        .adr_lo_in (na_lo),
        .dat_lo_in (nd_lo),
        .txn_hi_in (nt_hi),
        .adr_hi_in (na_hi),
        .dat_hi_in (nd_hi),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .txn_lo    (t_lo_w),
        .adr_lo    (a_lo_w),
        .txn_hi    (t_hi_w),
        .adr_hi    (a_hi_w)
    );
endmodule

// File: rtl/xcap_chk.sv
`timescale 1ns/100ps
module xcap_chk
    import xcap_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          acc_done,
    input logic          priv_viol,
    input logic          int_err,
    input logic          fin_ok,
    input logic [DW-1:0] t_lo,
    input logic [DW-1:0] a_lo,
    input logic [DW-1:0] t_hi,
    input logic [DW-1:0] a_hi
);
    // R11
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> !req_ready);

    // R11
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> req_ready);

    // R9
    viol_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_viol |-> acc_done);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_err |=> int_err);

    // R2
    slot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |-> t_lo[TX_VALID]);

    // R6
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |-> (a_lo[1:0] == 2'b00));

    // R7
    pair_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_ok && t_lo[TX_FIRST]) |->
            (a_hi == a_lo + DW'(4)) && t_hi[TX_VALID] && !t_hi[TX_FIRST]);
endmodule

bind xcap_unit xcap_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .acc_done  (acc_done),
    .priv_viol (priv_viol),
    .int_err   (int_err),
    .fin_ok    (fin_ok),
    .t_lo      (t_lo_w),
    .a_lo      (a_lo_w),
    .t_hi      (t_hi_w),
    .a_hi      (a_hi_w)
);

// File: tb/xcap_unit_tb.sv
`timescale 1ns/100ps
module xcap_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic        req_le = 1'b0;
    logic [4:0]  req_dreg = 5'd0;
    logic        req_super = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata_a = '0;
    logic [31:0] req_wdata_b = '0;
    logic        acc_done;
    logic        priv_viol;
    logic        int_err;
    logic [2:0]  rd_sel = 3'd0;
    logic [31:0] rd_data;

    xcap_unit u_dut (.*);

    always #4 clk = ~clk;

    typedef struct {
        logic [31:0] w [6];
        logic        viol;
        logic        err;
        int          lat;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model [6];
    logic        err_m = 1'b0;
    int          vec = 0;
    int          miss = 0;
    int          cyc = 0;
    int          issue_cyc = 0;
    bit          mon_busy = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string sel_tag(input int k);
        case (k)
            0: return "R2 R3 R4 R5 slot1 txn";
            1: return "R6 slot1 addr";
            2: return "R6 slot1 data";
            3: return "R7 slot2 txn";
            4: return "R8 slot2 addr";
            5: return "R8 slot2 data";
            default: return "R12 unused select";
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    endtask

    // driver: computes expectations from the requirements and offers the access
    task automatic issue(input bit st, input int sz, input bit sg, input bit le,
                         input int dr, input bit sup, input bit usr,
                         input logic [31:0] ad, input logic [31:0] wa,
                         input logic [31:0] wb, input bit poke);
        exp_t        e;
        logic [3:0]  be;
        logic [31:0] base;
        bit          bad;
        bad = !st && (dr == 0 || (sz == 3 && dr == 31));
        if (bad) begin
            err_m = 1'b1;
            e.viol = 1'b0;
            e.lat = 1;
        end else begin
            case (sz)
                0: be = 4'b0001 << (3 - ad[1:0]);
                1: be = ad[1] ? 4'b0011 : 4'b1100;
                default: be = 4'b1111;
            endcase
            base = 32'd1;
            base[1] = st;
            base[5:2] = be;
            base[10:6] = st ? 5'd0 : 5'(dr);
            base[11] = !st && sg;
            base[12] = le;
            base[13] = sup && !usr;
            model[0] = base;
            model[0][14] = (sz == 3);
            model[1] = {ad[31:2], 2'b00};
            model[2] = st ? wa : 32'd0;
            if (sz == 3) begin
                model[3] = base;
                if (!st) model[3][10:6] = 5'(dr + 1);
                model[4] = model[1] + 32'd4;
                if (st) model[5] = wb;
            end else begin
                model[3] = 32'd0;
            end
            e.viol = usr && !sup;
            e.lat = (sz == 3) ? 3 : 2;
        end
        for (int k = 0; k < 6; k++) e.w[k] = model[k];
        e.err = err_m;
        sb.push_back(e);

        @(negedge clk);
        req_store = st; req_size = 2'(sz); req_signed = sg; req_le = le;
        req_dreg = 5'(dr); req_super = sup; req_user = usr;
        req_addr = ad; req_wdata_a = wa; req_wdata_b = wb;
        req_valid = 1'b1;
        issue_cyc = cyc;
        @(negedge clk);
        if (poke) begin
            // R11: offered while busy, must be ignored
            req_store = ~st; req_size = 2'd0; req_dreg = 5'd0;
            req_addr = 32'hDEAD_BEEF; req_wdata_a = 32'h0BAD_0BAD;
            req_user = 1'b1; req_super = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (sb.size() != 0 || mon_busy) @(negedge clk);
    endtask

    // monitor: pops expectations as completions appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && acc_done) begin
                exp_t e;
                mon_busy = 1'b1;
                if (sb.size() == 0) begin
                    miss++;
                    $display("FAIL R11 act=unexpected done exp=none");
                end else begin
                    e = sb.pop_front();
                    chk("R11 latency", 32'(cyc - issue_cyc), 32'(e.lat));
                    chk("R11 ready low at done", {31'd0, req_ready}, 32'd0);
                    chk("R9 priv_viol", {31'd0, priv_viol}, {31'd0, e.viol});
                    chk("R10 int_err", {31'd0, int_err}, {31'd0, e.err});
                    @(negedge clk);
                    chk("R11 ready after done", {31'd0, req_ready}, 32'd1);
                    for (int k = 0; k < 8; k++) begin
                        rd_sel = 3'(k);
                        #0.4;
                        chk(sel_tag(k), rd_data, (k < 6) ? e.w[k] : 32'd0);
                    end
                end
                mon_busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miss++;
        $display("FAIL watchdog act=hung exp=complete");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 6; k++) model[k] = 32'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 done", {31'd0, acc_done}, 32'd0);
        chk("R1 viol", {31'd0, priv_viol}, 32'd0);
        chk("R1 err", {31'd0, int_err}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            rd_sel = 3'(k);
            #0.4;
            chk("R1 R12 reset word", rd_data, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: signed little-endian word load in supervisor mode
        issue(0, 2, 1, 1, 5, 1, 0, 32'h1000_0008, 32'h1111_1111, 32'h2222_2222, 0);
        // R5: byte stores at every offset
        for (int k = 0; k < 4; k++)
            issue(1, 0, 0, 0, 3, 0, 0, 32'h2000_0100 + 32'(k), 32'hA5A5_0000 + 32'(k), 32'h0, 0);
        // R5: halfword loads, both positions
        issue(0, 1, 1, 0, 9, 1, 0, 32'h3000_0040, 32'h0, 32'h0, 0);
        issue(0, 1, 0, 1, 10, 0, 0, 32'h3000_0042, 32'h0, 32'h0, 0);
        // R7: doubleword store, then doubleword load with destination 30
        issue(1, 3, 0, 0, 4, 1, 0, 32'h4000_0010, 32'hCAFE_0001, 32'hCAFE_0002, 1);
        issue(0, 3, 0, 1, 30, 1, 0, 32'h4000_0020, 32'h5555_5555, 32'h6666_6666, 0);
        // R8: single store after a pair keeps slot-two address and data
        issue(1, 2, 1, 0, 7, 1, 0, 32'h5000_0007, 32'h7777_7777, 32'h8888_8888, 1);
        // R9: user-space access outside supervisor, and inside it
        issue(0, 2, 0, 0, 12, 0, 1, 32'h6000_0000, 32'h0, 32'h0, 0);
        issue(1, 2, 0, 0, 0, 1, 1, 32'h6000_0004, 32'h9999_9999, 32'h0, 0);
        issue(0, 3, 0, 0, 20, 0, 1, 32'h6000_0008, 32'h0, 32'h0, 0);
        // R10: illegal destinations are refused
        issue(0, 2, 0, 0, 0, 1, 0, 32'h7000_0000, 32'h0, 32'h0, 0);
        issue(0, 3, 0, 0, 31, 1, 0, 32'h7000_0008, 32'h0, 32'h0, 0);
        // R10: flag stays set across later good accesses
        issue(0, 0, 1, 1, 31, 1, 0, 32'h7000_0013, 32'h0, 32'h0, 1);
        issue(1, 3, 0, 1, 31, 0, 0, 32'h7000_0018, 32'hABCD_0001, 32'hABCD_0002, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule